// File: doc/BRIEF.md
# Switchable 32 KB Program Window Mapper

This block sits between the 6502-style CPU bus of an 8-bit console and a cartridge program ROM. One bank register chooses which 32 KB slice of the ROM appears across the CPU's upper half, $8000 to $FFFF. The register has no read path. It loads on any CPU write to that upper half. The board has no write buffer, so the ROM drives the data bus while the CPU writes. The captured byte is therefore the CPU data ANDed with the ROM byte at the written address. Software writes to a location that already holds the wanted value to avoid this.

Two build options change the block. In the compact build the bank field is 2 bits wide (128 KB of ROM). In the extended build it is 4 bits wide (512 KB). In the fixed-mirroring build, a static strap selects horizontal or vertical nametable arrangement. In the single-screen build, register bit 4 selects the nametable page. On the video side, an unbanked 8 KB pattern RAM is addressed directly from the video bus. The hardware leaves the register contents undefined at power-on, so the model loads a value set by a parameter, which need not be zero.

Top module: `prg_window_mapper`

## Requirements
- R1: When `cpu_m2` is high, `cpu_rw_n` is low and `cpu_addr[15]` is high, the bank register loads on the next `clk` rising edge, whatever the values of `cpu_addr[14:0]`.
- R2: A write with `cpu_addr[15]` low, or with `cpu_m2` low, leaves the register unchanged. The block does not decode addresses below $8000.
- R3: The value loaded is `cpu_data & rom_data`, the CPU byte ANDed with the ROM byte at the written address.
- R4: `rom_addr` equals {bank, `cpu_addr[14:0]`}. With OVERSIZE=0 the bank is bits 1:0 of the loaded value, and bits 7:2 have no effect on `rom_addr`.
- R5: With OVERSIZE=1 the bank is bits 3:0 of the loaded value, and `rom_addr` is 19 bits wide.
- R6: While `rst_n` is low, the register holds INIT_REG: bank = INIT_REG bits (width-masked), screen bit = INIT_REG[4].
- R7: `rom_ce_n` is low exactly when `cpu_m2` is high, `cpu_rw_n` is high and `cpu_addr[15]` is high.
- R8: With SINGLE_SCREEN=0, `ciram_a10` equals `ppu_addr[10]` when `strap_vertical`=1 (vertical arrangement) and equals `ppu_addr[11]` when `strap_vertical`=0 (horizontal arrangement).
- R9: With SINGLE_SCREEN=1, `ciram_a10` equals register bit 4 (the value loaded from data bit 4), regardless of `strap_vertical` and `ppu_addr`.
- R10: `chr_addr` equals `ppu_addr[12:0]`, and `chr_ce_n` is low exactly when `ppu_addr[13]` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the register |
| rst_n | input | 1 | Active-low reset, loads INIT_REG |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw_n | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU phase-2 qualifier |
| rom_data | input | 8 | Byte the ROM presents at the current address |
| rom_addr | output | 15+BANK_BITS | Program ROM address |
| rom_ce_n | output | 1 | Program ROM chip enable, active low |
| strap_vertical | input | 1 | Mirroring strap, 1 = vertical |
| ppu_addr | input | 14 | Video bus address |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |
| chr_addr | output | 13 | Pattern RAM address |
| chr_ce_n | output | 1 | Pattern RAM enable, active low |

## Verification
A register write and a ROM byte that disagrees with the written data occur in the same cycle. The bench sweeps all 256 data values against several ROM bytes at varying low address bits. It then checks that both the bank and the screen bit equal the bitwise AND. Register writes that flip bit 4 also coincide with a video address held steady. The bench judges that `ciram_a10` changes only after the clock edge of the write and follows the new bit in the single-screen build. In the fixed build it keeps following the strap-selected address bit.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int WIN_BITS = 15;
    localparam int BANK_FIELD = 4;

    typedef struct packed {
        logic                  screen;
        logic [BANK_FIELD-1:0] bank;
    } bank_reg_t;
endpackage

// File: rtl/bank_latch_unit.sv
module bank_latch_unit
    import mapper_pkg::*;
#(
    parameter int         BANK_BITS = 2,
    parameter logic [7:0] INIT_REG  = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [4:0]           wr_val,
    output logic [BANK_BITS-1:0] bank_o,
    output logic                 screen_o
);
    localparam logic [BANK_FIELD-1:0] BANK_MASK = BANK_FIELD'((1 << BANK_BITS) - 1);

    bank_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.screen = wr_val[4];
            st_d.bank   = wr_val[3:0] & BANK_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.screen <= INIT_REG[4];
            st_q.bank   <= INIT_REG[3:0] & BANK_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o   = st_q.bank[BANK_BITS-1:0];
    assign screen_o = st_q.screen;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(st_q));

    p_conflict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (st_q.bank == ($past(wr_val[3:0]) & BANK_MASK))
                   && (st_q.screen == $past(wr_val[4])));

    p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bank & ~BANK_MASK) == '0);
endmodule

// File: rtl/rom_window_map.sv
module rom_window_map
    import mapper_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic [BANK_BITS-1:0]          bank,
    input  logic [15:0]                   cpu_addr,
    input  logic                          cpu_rw_n,
    input  logic                          cpu_m2,
    output logic [WIN_BITS+BANK_BITS-1:0] rom_addr,
    output logic                          rom_ce_n
);
    always_comb begin
        rom_addr = {bank, cpu_addr[WIN_BITS-1:0]};
        rom_ce_n = !(cpu_addr[15] && cpu_rw_n && cpu_m2);
    end
endmodule

// File: rtl/nt_mirror_sel.sv
module nt_mirror_sel #(
    parameter bit SINGLE_SCREEN = 1'b0
) (
    input  logic screen,
    input  logic strap_vertical,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic ciram_a10
);
    if (SINGLE_SCREEN) begin : g_one_page
        logic unused_mir;
        assign unused_mir = ^{strap_vertical, ppu_a10, ppu_a11};
        assign ciram_a10  = screen;
    end else begin : g_strap
        logic unused_scr;
        assign unused_scr = screen;
        assign ciram_a10  = strap_vertical ? ppu_a10 : ppu_a11;
    end
endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
    import mapper_pkg::*;
#(
    parameter bit         OVERSIZE      = 1'b0,
    parameter bit         SINGLE_SCREEN = 1'b0,
    parameter logic [7:0] INIT_REG      = 8'h03,
    localparam int        BANK_BITS     = OVERSIZE ? 4 : 2,
    localparam int        ROM_AW        = WIN_BITS + BANK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw_n,
    input  logic              cpu_m2,
    input  logic [7:0]        rom_data,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce_n,
    input  logic              strap_vertical,
    input  logic [13:0]       ppu_addr,
    output logic              ciram_a10,
    output logic [12:0]       chr_addr,
    output logic              chr_ce_n
);
    logic                 wr_stb;
    logic [7:0]           bus_val;
    logic [BANK_BITS-1:0] bank;
    logic                 screen;
    logic                 unused_top;

    // The ROM drives the bus during the write, so the two drivers resolve as AND.
    assign wr_stb     = cpu_m2 && !cpu_rw_n && cpu_addr[15];
    assign bus_val    = cpu_data & rom_data;
    assign unused_top = ^bus_val[7:5];

    bank_latch_unit #(.BANK_BITS(BANK_BITS), .INIT_REG(INIT_REG)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_val   (bus_val[4:0]),
        .bank_o   (bank),
        .screen_o (screen)
    );

    rom_window_map #(.BANK_BITS(BANK_BITS)) u_map (
        .bank     (bank),
        .cpu_addr (cpu_addr),
        .cpu_rw_n (cpu_rw_n),
        .cpu_m2   (cpu_m2),
        .rom_addr (rom_addr),
        .rom_ce_n (rom_ce_n)
    );

    nt_mirror_sel #(.SINGLE_SCREEN(SINGLE_SCREEN)) u_mir (
        .screen         (screen),
        .strap_vertical (strap_vertical),
        .ppu_a10        (ppu_addr[10]),
        .ppu_a11        (ppu_addr[11]),
        .ciram_a10      (ciram_a10)
    );

    assign chr_addr = ppu_addr[12:0];
    assign chr_ce_n = ppu_addr[13];

    p_ce_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[15] |-> rom_ce_n);

    p_chr_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_addr[13] |-> chr_ce_n);
endmodule

// File: tb/sim_prg_window_mapper.sv
module sim_prg_window_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw_n = 1'b1;
    logic        cpu_m2 = 1'b0;
    logic [7:0]  rom_data = 8'hFF;
    logic        strap_vertical = 1'b1;
    logic [13:0] ppu_addr = 14'h0000;

    logic [16:0] rom_addr0;
    logic [18:0] rom_addr1;
    logic        rom_ce_n0, rom_ce_n1, ciram0, ciram1, chr_ce_n0, chr_ce_n1;
    logic [12:0] chr_addr0, chr_addr1;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prg_window_mapper #(.OVERSIZE(1'b0), .SINGLE_SCREEN(1'b0), .INIT_REG(8'h03)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2), .rom_data(rom_data),
        .rom_addr(rom_addr0), .rom_ce_n(rom_ce_n0), .strap_vertical(strap_vertical),
        .ppu_addr(ppu_addr), .ciram_a10(ciram0), .chr_addr(chr_addr0), .chr_ce_n(chr_ce_n0)
    );

    prg_window_mapper #(.OVERSIZE(1'b1), .SINGLE_SCREEN(1'b1), .INIT_REG(8'h1A)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2), .rom_data(rom_data),
        .rom_addr(rom_addr1), .rom_ce_n(rom_ce_n1), .strap_vertical(strap_vertical),
        .ppu_addr(ppu_addr), .ciram_a10(ciram1), .chr_addr(chr_addr1), .chr_ce_n(chr_ce_n1)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic [7:0] r, input logic m2);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; rom_data = r; cpu_rw_n = 1'b0; cpu_m2 = m2;
        @(negedge clk);
        cpu_rw_n = 1'b1; cpu_m2 = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic bus_read(input logic [15:0] a);
        cpu_addr = a; cpu_rw_n = 1'b1; cpu_m2 = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  v, r, m;
        logic [15:0] a;
        logic        old0, old1;
        repeat (3) @(negedge clk);
        // R6: parameterised power-on contents
        bus_read(16'h8000);
        check("R6 base init bank", 32'(rom_addr0), 32'h18000);
        check("R6 oversize init bank", 32'(rom_addr1), 32'h50000);
        check("R6 init screen", 32'(ciram1), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4 R5 R9: sweep every data value against several ROM bytes
        for (int pass = 0; pass < 3; pass++) begin
            for (int i = 0; i < 256; i++) begin
                v = 8'(i);
                r = (pass == 0) ? 8'hFF : (pass == 1) ? 8'(i * 37 + 5) : 8'hAA;
                a = 16'h8000 | 16'(i * 16'h0101 + pass * 16'h2345);
                bus_write(a, v, r, 1'b1);
                m = v & r;
                a = 16'h8000 | 16'(i * 16'h0093);
                bus_read(a);
                check("R4 base window", 32'(rom_addr0), {15'd0, m[1:0], a[14:0]});
                check("R5 oversize window", 32'(rom_addr1), {13'd0, m[3:0], a[14:0]});
                check("R9 screen bit", 32'(ciram1), 32'(m[4]));
                @(negedge clk);
            end
        end

        // R2: writes below $8000 or without M2 are ignored
        bus_write(16'h8000, 8'h11, 8'hFF, 1'b1); // bank 1/1, screen 1
        bus_write(16'h7FFD, 8'h02, 8'hFF, 1'b1);
        bus_read(16'hC000);
        check("R2 low-half write ignored base", 32'(rom_addr0), 32'h0C000);
        check("R2 low-half write ignored over", 32'(rom_addr1), 32'h0C000);
        check("R2 low-half screen kept", 32'(ciram1), 32'd1);
        @(negedge clk);
        bus_write(16'hFFFF, 8'h03, 8'hFF, 1'b0);
        bus_read(16'hC000);
        check("R2 no-M2 write ignored", 32'(rom_addr1), 32'h0C000);
        check("R2 no-M2 screen kept", 32'(ciram1), 32'd1);
        @(negedge clk);

        // R7: chip enable
        bus_read(16'h8000);  check("R7 ce upper read", 32'(rom_ce_n0), 32'd0);
        bus_read(16'h6000);  check("R7 ce lower read", 32'(rom_ce_n0), 32'd1);
        cpu_addr = 16'hF000; cpu_m2 = 1'b0; #1;
        check("R7 ce no M2", 32'(rom_ce_n1), 32'd1);
        cpu_m2 = 1'b1; cpu_rw_n = 1'b0; #1;
        check("R7 ce on write", 32'(rom_ce_n0), 32'd1);
        cpu_rw_n = 1'b1; cpu_m2 = 1'b0;
        @(negedge clk);

        // R8 R9 R10: video bus sweep with both strap settings
        for (int s = 0; s < 2; s++) begin
            strap_vertical = s[0];
            for (int p = 0; p < 64; p++) begin
                ppu_addr = 14'(p * 14'h0100 + p * 3);
                #1;
                check("R8 fixed mirroring", 32'(ciram0),
                      32'(s[0] ? ppu_addr[10] : ppu_addr[11]));
                check("R9 strap ignored", 32'(ciram1), 32'd1);
                check("R10 pattern addr", 32'(chr_addr0), 32'(ppu_addr[12:0]));
                check("R10 pattern enable", 32'(chr_ce_n1), 32'(ppu_addr[13]));
            end
        end

        // R9 R8: screen bit flipped while video address held
        ppu_addr = 14'h2400; strap_vertical = 1'b1;
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_data = 8'h00; rom_data = 8'hFF; cpu_rw_n = 1'b0; cpu_m2 = 1'b1;
        #1;
        old0 = ciram0; old1 = ciram1;
        check("R9 no change before edge", 32'(old1), 32'd1);
        @(negedge clk);
        cpu_rw_n = 1'b1; cpu_m2 = 1'b0;
        #1;
        check("R9 screen cleared after edge", 32'(ciram1), 32'd0);
        check("R8 fixed follows A10", 32'(ciram0), 32'(old0));
        check("R8 fixed value", 32'(ciram0), 32'd1);

        // R6: reset restores initial contents
        rst_n = 1'b0; #1;
        bus_read(16'h8001);
        check("R6 reset again base", 32'(rom_addr0), 32'h18001);
        check("R6 reset again over", 32'(rom_addr1), 32'h50001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule